// File: doc/BRIEF.md
# Self-Recovering Supply Supervisor and Watchdog

This block sequences the power-good warning and the reset lines of a microcontroller. It takes comparator decisions that are already digital: the monitored input is above its high threshold, below its early-warning threshold, or below its reset threshold, and the supply is above its turn-on level and above its turn-off level. It also takes an active-low timer-clear strobe from the host. From these it drives an active-low warning line (`save_n`) and a reset line in both polarities. All inputs and outputs are plain level signals; the block has no streaming interface and applies no back-pressure.

One period of `PERIOD_CYC` clock cycles sets both the initialization reset length and the watchdog expiry. A debounce of `PERIOD_CYC/64` cycles gates the release of the warning line at power-up. After a watchdog expiry, reset is held for one period and then released on its own. With no clears, reset therefore toggles indefinitely. Any power-down condition overrides the watchdog and forces a full initialization on recovery. The host keeps reset released by strobing `wd_clear_n` low more often than once per period.

Top module: `sup_wdog`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, `save_n`=0, `rst_n`=0 and `rst_p`=1.
- R2: `save_n` rises exactly `PERIOD_CYC/64` clock edges after the edge that first sees both `in_above_hi`=1 and `sup_above_on`=1 (with `sup_above_off`=1 and `in_below_rst`=0), whichever of the two came last.
- R3: `rst_n` rises, and `rst_p` falls, exactly `PERIOD_CYC` edges after `save_n` rises. Clear strobes during this initialization period have no effect on that timing.
- R4: Once reset is released, it asserts again after exactly `PERIOD_CYC` edges unless a valid clear arrives. A valid clear restarts that count.
- R5: A watchdog reset lasts exactly `PERIOD_CYC` edges and then releases. With no clears, reset is a square wave of period `2*PERIOD_CYC`.
- R6: A valid clear during a watchdog reset releases reset and restarts the watchdog count from zero.
- R7: `wd_clear_n` passes through two synchronizer flops. It counts as a valid clear only after it has been low for `MIN_LOW` synchronized cycles. With `MIN_LOW`=2, reset releases on the 4th edge after the input goes low. A low of one cycle is ignored.
- R8: `in_below_warn`=1 drives `save_n` low one edge later, and reset is unaffected. `save_n` returns high one edge after the flag clears.
- R9: `in_below_rst`=1 or `sup_above_on`=0 asserts all outputs one edge later, and clears are ignored while the condition holds. Recovery repeats the full debounce and initialization sequence.
- R10: `sup_above_off`=0 asserts `save_n`, `rst_n` and `rst_p` one edge later, regardless of every other input.
- R11: `rst_p` is always the complement of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, forces the power-up state |
| in_above_hi | input | 1 | Monitored input is above its high threshold |
| in_below_warn | input | 1 | Monitored input is below its early-warning threshold |
| in_below_rst | input | 1 | Monitored input is below its reset threshold |
| sup_above_on | input | 1 | Supply is above its turn-on level |
| sup_above_off | input | 1 | Supply is above its turn-off level |
| wd_clear_n | input | 1 | Asynchronous watchdog clear strobe, active low |
| save_n | output | 1 | Power-good warning, low = warning |
| rst_n | output | 1 | Reset, active low |
| rst_p | output | 1 | Reset, active high |

## Verification
The sequence is driven through a power-up in which the input flag rises long before the supply flag, so that the debounce timing shows which of the two events it starts from. The watchdog is then run with no clears at all, with a single-cycle glitch, with clears landing during a timeout reset, and with regular clears at half a period. Each case is sampled at the exact edge of the expected transition and at the edge before it, which tells a correct count from counts that are one off. The warning, reset-threshold, turn-on and turn-off flags are each raised from a running state. This separates the SAVE-only warning from a full re-initialization and from the immediate forced state. One power-up also carries a long clear strobe during initialization, to show that clears cannot shorten it.

// File: rtl/supwd_pkg.sv
package supwd_pkg;
  typedef enum logic [2:0] {
    SV_DOWN,
    SV_DEBOUNCE,
    SV_INIT,
    SV_RUN,
    SV_TRIP
  } sv_state_e;

  function automatic logic save_ok(input sv_state_e s);
    return (s == SV_INIT) || (s == SV_RUN) || (s == SV_TRIP);
  endfunction
endpackage

// File: rtl/supwd_clr_filter.sv
module supwd_clr_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_n_async,
  output logic clr_valid
);
  localparam int LW = $clog2(MIN_LOW + 1);

  logic [SYNC_STAGES-1:0] chain;
  logic [LW-1:0]          low_run;
  logic                   clr_s;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= clr_n_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign clr_s = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || clr_s)                low_run <= '0;
    else if (low_run != LW'(MIN_LOW)) low_run <= low_run + 1'b1;
  end

  assign clr_valid = !clr_s && (low_run == LW'(MIN_LOW - 1));
endmodule

// File: rtl/supwd_timer.sv
module supwd_timer #(
  parameter int PERIOD_CYC = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic db_done,
  output logic to_done
);
  localparam int CW     = $clog2(PERIOD_CYC);
  localparam int DB_CYC = PERIOD_CYC / 64;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign db_done = (cnt == CW'(DB_CYC - 1));
  assign to_done = (cnt == CW'(PERIOD_CYC - 1));
endmodule

// File: rtl/supwd_fsm.sv
module supwd_fsm
  import supwd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      in_above_hi,
  input  logic      in_below_rst,
  input  logic      sup_above_on,
  input  logic      sup_above_off,
  input  logic      clr_valid,
  input  logic      db_done,
  input  logic      to_done,
  output logic      restart,
  output sv_state_e st_next
);
  sv_state_e st;
  logic      pwr_ok;

  assign pwr_ok = sup_above_off && sup_above_on && !in_below_rst;

  always_comb begin
    st_next = st;
    unique case (st)
      SV_DOWN:     if (in_above_hi) st_next = SV_DEBOUNCE;
      SV_DEBOUNCE: if (!in_above_hi) st_next = SV_DOWN;
                   else if (db_done) st_next = SV_INIT;
      SV_INIT:     if (to_done) st_next = SV_RUN;
      SV_RUN:      if (!clr_valid && to_done) st_next = SV_TRIP;
      SV_TRIP:     if (clr_valid || to_done) st_next = SV_RUN;
      default:     st_next = SV_DOWN;
    endcase
    if (!pwr_ok) st_next = SV_DOWN;
  end

  assign restart = (st_next != st) || (st == SV_RUN && clr_valid && pwr_ok);

  always_ff @(posedge clk) begin
    if (rst) st <= SV_DOWN;
    else     st <= st_next;
  end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import supwd_pkg::*;
#(
  parameter int PERIOD_CYC  = 256,
  parameter int MIN_LOW     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_above_hi,
  input  logic in_below_warn,
  input  logic in_below_rst,
  input  logic sup_above_on,
  input  logic sup_above_off,
  input  logic wd_clear_n,
  output logic save_n,
  output logic rst_n,
  output logic rst_p
);
  logic      clr_valid;
  logic      db_done;
  logic      to_done;
  logic      restart;
  sv_state_e st_next;

  supwd_clr_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_LOW    (MIN_LOW)
  ) u_filt (
    .clk        (clk),
    .rst        (rst),
    .clr_n_async(wd_clear_n),
    .clr_valid  (clr_valid)
  );

  supwd_timer #(
    .PERIOD_CYC(PERIOD_CYC)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .db_done(db_done),
    .to_done(to_done)
  );

  supwd_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .in_above_hi  (in_above_hi),
    .in_below_rst (in_below_rst),
    .sup_above_on (sup_above_on),
    .sup_above_off(sup_above_off),
    .clr_valid    (clr_valid),
    .db_done      (db_done),
    .to_done      (to_done),
    .restart      (restart),
    .st_next      (st_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      save_n <= 1'b0;
      rst_n  <= 1'b0;
      rst_p  <= 1'b1;
    end else begin
      save_n <= save_ok(st_next) && !in_below_warn;
      rst_n  <= (st_next == SV_RUN);
      rst_p  <= (st_next != SV_RUN);
    end
  end
endmodule

// File: rtl/sup_wdog_chk.sv
module sup_wdog_chk (
  input logic clk,
  input logic rst,
  input logic in_below_warn,
  input logic in_below_rst,
  input logic sup_above_on,
  input logic sup_above_off,
  input logic save_n,
  input logic rst_n,
  input logic rst_p
);
  AST_RESET_ALL_ACTIVE: assert property (@(posedge clk)
    rst |=> (!save_n && !rst_n && rst_p)); // R1

  AST_WARN_DROPS_SAVE: assert property (@(posedge clk) disable iff (rst)
    in_below_warn |=> !save_n); // R8

  AST_BROWNOUT_RESET: assert property (@(posedge clk) disable iff (rst)
    (in_below_rst || !sup_above_on) |=> (!rst_n && !save_n)); // R9

  AST_OFF_ALL_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !sup_above_off |=> (!save_n && !rst_n && rst_p)); // R10

  AST_POLARITY_PAIR: assert property (@(posedge clk) disable iff (rst)
    rst_n != rst_p); // R11
endmodule

bind sup_wdog sup_wdog_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_below_warn(in_below_warn),
  .in_below_rst (in_below_rst),
  .sup_above_on (sup_above_on),
  .sup_above_off(sup_above_off),
  .save_n       (save_n),
  .rst_n        (rst_n),
  .rst_p        (rst_p)
);

// File: tb/sim_sup_wdog.sv
module sim_sup_wdog;
  localparam int T  = 256;
  localparam int DB = T / 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_above_hi = 1'b0, in_below_warn = 1'b0, in_below_rst = 1'b0;
  logic sup_above_on = 1'b0, sup_above_off = 1'b1, wd_clear_n = 1'b1;
  logic save_n, rst_n, rst_p;

  int n_tests = 0;
  int n_fail  = 0;

  // encodings used in checks: {save_n, rst_n, rst_p}
  localparam logic [2:0] ALL_ACT = 3'b001;
  localparam logic [2:0] INITING = 3'b101;
  localparam logic [2:0] RUNNING = 3'b110;
  localparam logic [2:0] WARNING = 3'b010;

  sup_wdog #(.PERIOD_CYC(T), .MIN_LOW(2), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .in_above_hi(in_above_hi), .in_below_warn(in_below_warn),
    .in_below_rst(in_below_rst), .sup_above_on(sup_above_on), .sup_above_off(sup_above_off),
    .wd_clear_n(wd_clear_n), .save_n(save_n), .rst_n(rst_n), .rst_p(rst_p)
  );

  always #10 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    n_tests++;
    if ({save_n, rst_n, rst_p} !== exp) begin
      n_fail++;
      $display("FAIL %s: {save_n,rst_n,rst_p} actual %b expected %b at %0t",
               req, {save_n, rst_n, rst_p}, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(2);
    check("R1 in reset", ALL_ACT);
    rst = 1'b0;
    step(1);
    check("R1 after reset", ALL_ACT);
  endtask

  // from DOWN: all good flags set at this negedge; ends one cycle after release
  task automatic t_powerup(input string tag);
    sup_above_off = 1'b1; in_below_rst = 1'b0;
    in_above_hi = 1'b1; sup_above_on = 1'b1;
    step(DB);
    check({"R2 debounce hold ", tag}, ALL_ACT);
    step(1);
    check({"R2 save release ", tag}, INITING);
    step(T - 1);
    check({"R3 init hold ", tag}, INITING);
    step(1);
    check({"R3 reset release ", tag}, RUNNING);
  endtask

  task automatic t_later_event();
    in_above_hi = 1'b1;
    step(20);
    check("R2 input high without supply", ALL_ACT);
    t_powerup("supply last");
  endtask

  task automatic t_square();
    for (int k = 0; k < 2; k++) begin
      step(T - 1);
      check("R4 expiry edge-1", RUNNING);
      step(1);
      check("R4 expiry", INITING);
      step(T - 1);
      check("R5 timeout hold", INITING);
      step(1);
      check("R5 self release", RUNNING);
    end
  endtask

  // starts one cycle after release; ends on TRIP entry
  task automatic t_short_glitch();
    step(10);
    wd_clear_n = 1'b0;
    step(1);
    wd_clear_n = 1'b1;
    step(T - 12);
    check("R7 glitch ignored, edge-1", RUNNING);
    step(1);
    check("R7 glitch ignored, expiry", INITING);
  endtask

  // starts at TRIP entry
  task automatic t_trip_clear();
    step(5);
    wd_clear_n = 1'b0;
    step(3);
    check("R7 filter delay", INITING);
    step(1);
    check("R6 clear releases timeout reset", RUNNING);
    wd_clear_n = 1'b1;
    step(T - 1);
    check("R6 restarted count, edge-1", RUNNING);
    step(1);
    check("R6 restarted count expiry", INITING);
  endtask

  task automatic t_keepalive();
    bit ok = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wd_clear_n = 1'b0;
      step(3);
      wd_clear_n = 1'b1;
      step(T / 2 - 3);
      if (rst_n !== 1'b1) ok = 1'b0;
    end
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R4 keepalive: rst_n actual %b expected 1", rst_n);
    end
    check("R4 keepalive state", RUNNING);
  endtask

  task automatic t_warn();
    in_below_warn = 1'b1;
    step(1);
    check("R8 warning", WARNING);
    step(3);
    check("R8 warning held, reset off", WARNING);
    in_below_warn = 1'b0;
    step(1);
    check("R8 warning cleared", RUNNING);
  endtask

  task automatic t_brownout();
    in_below_rst = 1'b1;
    step(1);
    check("R9 below reset threshold", ALL_ACT);
    wd_clear_n = 1'b0;
    step(6);
    wd_clear_n = 1'b1;
    step(3);
    check("R9 clear ignored in brownout", ALL_ACT);
    t_powerup("R9 recovery");
  endtask

  task automatic t_supply_on_drop();
    sup_above_on = 1'b0;
    step(1);
    check("R9 supply below turn-on", ALL_ACT);
    step(5);
  endtask

  // from DOWN, long clear during init must not shorten it
  task automatic t_init_clear();
    in_above_hi = 1'b1; sup_above_on = 1'b1;
    step(DB + 1);
    check("R2 save release before init clear", INITING);
    wd_clear_n = 1'b0;
    step(6);
    wd_clear_n = 1'b1;
    step(T - 1 - 6);
    check("R3 clear ignored during init", INITING);
    step(1);
    check("R3 release after full init", RUNNING);
  endtask

  task automatic t_off();
    sup_above_off = 1'b0;
    in_below_warn = 1'b0;
    step(1);
    check("R10 turn-off forces all active", ALL_ACT);
    step(4);
    check("R10 held", ALL_ACT);
    t_powerup("R10 recovery");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_later_event();
    t_square();
    t_short_glitch();
    t_trip_clear();
    t_keepalive();
    t_warn();
    t_brownout();
    t_supply_on_drop();
    t_init_clear();
    t_off();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule